// File: doc/BRIEF.md
# Dual-Mode Word Address Counter

This block keeps the current word address of a byte-wide serial memory. A protocol front end hands it the two address bytes of a transfer, high byte first, each with its own load strobe. After every data byte moved, the front end pulses one of two increment strobes. A write increment counts only within the current 64-byte page. A read increment counts through the whole 16,384-byte array. The address drives the storage array and the page write buffer directly.

The value stays as it is between transfers. Start and stop conditions do not reach this block. A read that gives no new address therefore continues from one past the last byte accessed. The address is split into an 8-bit page field (bits 13:6) and a 6-bit offset field (bits 5:0).

Top module: `waddr_ctr`

## Requirements
- R1: While `rst_ni` is low the address is 0, and it is still 0 on the first clock after release.
- R2: A cycle with `ld_hi_i` high writes `byte_i[5:0]` into address bits 13:8. `byte_i[7:6]` are ignored and address bits 7:0 keep their value.
- R3: A cycle with `ld_lo_i` high writes `byte_i[7:0]` into address bits 7:0, and bits 13:8 keep their value.
- R4: A write increment adds one to the offset, bits 5:0, modulo 64. The page, bits 13:6, is unchanged, so offset 63 is followed by offset 0 of the same page.
- R5: A read increment adds one to the full 14-bit address. A carry out of the offset advances the page, and 16383 is followed by 0.
- R6: When any load strobe is high, both increment strobes are ignored in that cycle.
- R7: In a cycle with no strobe the address holds its value, for any number of cycles.
- R8: When both increment strobes are high and no load is high, the write rule of R4 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_hi_i | input | 1 | Load the high address byte from `byte_i` |
| ld_lo_i | input | 1 | Load the low address byte from `byte_i` |
| byte_i | input | 8 | Received address byte |
| wr_inc_i | input | 1 | One data byte was written; step within the page |
| rd_inc_i | input | 1 | One data byte was read; step through the array |
| addr_o | output | 14 | Current word address |

## Verification
The hardest cases to reach are at the ends of the ranges. One is a read step from address 16383. Another is a write step from offset 63 in a page whose bits 13:8 are all ones. Counting there from reset would take thousands of strobes. The stimulus instead loads the high byte with its ignored top bits set and loads a chosen low byte, which places the counter one step from each wrap. From there it applies write, read and combined strobes. Later a randomized mix of loads and increments runs against a scoreboard model.

// File: rtl/waddr_pkg.sv
package waddr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFS_W  = 6;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned ADDR_W = OFS_W + PAGE_W;
  localparam int unsigned HI_W   = ADDR_W - BYTE_W;

  typedef logic [ADDR_W-1:0] waddr_t;
endpackage

// File: rtl/waddr_seg.sv
// One counter field: per-bit masked load with priority, increment, carry out.
module waddr_seg #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_mask_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (ld_i)       q_d = (q_q & ~ld_mask_i) | (ld_val_i & ld_mask_i);
    else if (inc_i) q_d = q_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = inc_i & ~ld_i & (q_q == ALL_ONES);

  // R6: a load overrides a same-cycle increment on every masked bit
  a_r6_seg_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && inc_i) |=> ((q_q & $past(ld_mask_i)) == ($past(ld_val_i) & $past(ld_mask_i))));
endmodule

// File: rtl/waddr_ctr.sv
module waddr_ctr
  import waddr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wr_inc_i,
  input  logic              rd_inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned LO_PAGE_W = BYTE_W - OFS_W;

  logic ld_any, inc_any, page_inc, ofs_carry, page_carry;
  waddr_t ld_mask, ld_val;
  logic [OFS_W-1:0]  ofs_q;
  logic [PAGE_W-1:0] page_q;

  assign ld_any  = ld_hi_i | ld_lo_i;
  assign inc_any = wr_inc_i | rd_inc_i;

  // Byte-aligned loads span field boundaries; express them as full-width masks
  assign ld_mask = {{HI_W{ld_hi_i}}, {BYTE_W{ld_lo_i}}};
  assign ld_val  = {byte_i[HI_W-1:0], byte_i};

  // Write rule wins when both increments are raised
  assign page_inc = ofs_carry & rd_inc_i & ~wr_inc_i;

  waddr_seg #(.W(OFS_W)) u_ofs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_any),
    .ld_mask_i (ld_mask[OFS_W-1:0]),
    .ld_val_i  (ld_val[OFS_W-1:0]),
    .inc_i     (inc_any),
    .q_o       (ofs_q),
    .carry_o   (ofs_carry)
  );

  waddr_seg #(.W(PAGE_W)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_any),
    .ld_mask_i (ld_mask[ADDR_W-1:OFS_W]),
    .ld_val_i  (ld_val[ADDR_W-1:OFS_W]),
    .inc_i     (page_inc),
    .q_o       (page_q),
    .carry_o   (page_carry)
  );

  assign addr_o = {page_q, ofs_q};

  // R1: out of reset at zero
  a_r1_reset_zero: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (addr_o == '0));

  // R2: high load ignores byte_i top bits, keeps low byte
  a_r2_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !ld_lo_i) |=> (addr_o == {$past(byte_i[HI_W-1:0]), $past(addr_o[BYTE_W-1:0])}));

  // R3: low load keeps the high part
  a_r3_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_hi_i) |=> (addr_o == {$past(addr_o[ADDR_W-1:BYTE_W]), $past(byte_i)}));

  // R4, R8: write step stays inside the page
  a_r4_wr_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inc_i && !ld_any) |=> (addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W]))
                              && (addr_o[OFS_W-1:0] == $past(addr_o[OFS_W-1:0]) + OFS_W'(1)));

  // R5: read step runs over the whole array
  a_r5_rd_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_inc_i && !wr_inc_i && !ld_any) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

  // R7: hold with no strobe
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_any && !inc_any) |=> $stable(addr_o));

  // R5: only a read step leaves the last page carry unused; never a page carry on write
  a_r4_no_page_carry_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inc_i |-> !page_inc && !page_carry);
endmodule

// File: tb/waddr_ctr_tb_top.sv
module waddr_ctr_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_hi_i = 1'b0, ld_lo_i = 1'b0, wr_inc_i = 1'b0, rd_inc_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [13:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [13:0] m_addr = '0;
  logic [13:0] exp_q[$];
  int          tag_q[$];
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  waddr_ctr dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
    .byte_i(byte_i), .wr_inc_i(wr_inc_i), .rd_inc_i(rd_inc_i), .addr_o(addr_o)
  );

  task automatic check(input logic [13:0] act, input logic [13:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: addr_o=%h expected %h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of strobes, updates the model, pushes expectation
  task automatic step(input bit hi, input bit lo, input logic [7:0] b,
                      input bit wr, input bit rd, input int req);
    @(negedge clk_i);
    ld_hi_i = hi; ld_lo_i = lo; byte_i = b; wr_inc_i = wr; rd_inc_i = rd;
    if (hi || lo) begin
      if (hi) m_addr[13:8] = b[5:0];
      if (lo) m_addr[7:0]  = b;
    end else if (wr) begin
      m_addr[5:0] = m_addr[5:0] + 6'd1;
    end else if (rd) begin
      m_addr = m_addr + 14'd1;
    end
    exp_q.push_back(m_addr);
    tag_q.push_back(req);
  endtask

  task automatic idle_wait();
    @(negedge clk_i);
    ld_hi_i = 0; ld_lo_i = 0; wr_inc_i = 0; rd_inc_i = 0;
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  // Monitor: compares one result per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() != 0) begin
        automatic logic [13:0] e = exp_q.pop_front();
        automatic int t = tag_q.pop_front();
        check(addr_o, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(addr_o, 14'h0000, 1);           // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(addr_o, 14'h0000, 1);           // R1 after release

    step(1, 0, 8'hFF, 0, 0, 2);           // R2: top bits ignored -> 3F00
    step(0, 1, 8'h3E, 0, 0, 3);           // R3 -> 3F3E
    step(1, 0, 8'hC5, 0, 0, 2);           // R2: low byte kept -> 053E
    step(1, 0, 8'h3F, 0, 0, 2);           // back to 3F3E
    step(0, 0, 8'h00, 1, 0, 4);           // R4 -> 3F3F
    step(0, 0, 8'h00, 1, 0, 4);           // R4 wrap in page -> 3F00
    step(0, 0, 8'h00, 1, 0, 4);           // R4 -> 3F01
    step(0, 1, 8'hFE, 0, 0, 3);           // -> 3FFE
    step(0, 0, 8'h00, 0, 1, 5);           // R5 -> 3FFF
    step(0, 0, 8'h00, 0, 1, 5);           // R5 array wrap -> 0000
    step(0, 1, 8'h3F, 0, 0, 3);           // -> 003F
    step(0, 0, 8'h00, 0, 1, 5);           // R5 page carry -> 0040
    step(0, 1, 8'h7F, 1, 1, 6);           // R6 load beats both incs -> 007F
    step(1, 0, 8'h12, 0, 1, 6);           // R6 -> 127F
    step(0, 0, 8'h00, 1, 1, 8);           // R8 offset 3F -> 1240 same page
    step(0, 1, 8'hFF, 0, 0, 3);           // -> 12FF
    step(0, 0, 8'h00, 1, 1, 8);           // R8 -> 12C0
    for (int i = 0; i < 5; i++) step(0, 0, 8'hAA, 0, 0, 7);  // R7 hold
    step(1, 1, 8'h5A, 0, 0, 2);           // R2, R3 together -> 1A5A
    for (int i = 0; i < 400; i++) begin
      automatic int unsigned r = $urandom;
      automatic bit hi = (r[3:0] == 0);
      automatic bit lo = (r[7:4] == 0);
      automatic bit wr = r[8];
      automatic bit rd = r[9];
      automatic int req = (hi || lo) ? 6 : (wr ? 4 : (rd ? 5 : 7));
      step(hi, lo, r[23:16], wr, rd, req);
    end
    idle_wait();

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check(addr_o, 14'h0000, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_addr = '0;
    step(0, 0, 8'h00, 0, 0, 7);
    step(0, 0, 8'h00, 0, 1, 5);           // R5 -> 0001
    idle_wait();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule